// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a wide set of level-sensitive interrupt sources and folds them onto a few output lines. The number of sources is a multiple of 32. Each source has its own enable bit and its own software-forced pending bit. The sources are split into groups of 64, and each group drives one output line per channel. A one-hot channel selector picks which set of output lines carries the groups. A master disable can silence individual groups, and a master status register shows which groups have pending work.

Software reaches the block through a small 32-bit register port. The port has separate write and read strobes, a byte address and a write data word. Read data is registered and comes back one cycle after the read strobe. Register banks are indexed in reverse, so the highest-numbered sources live in the lowest-addressed bank word. The bank start addresses move with the number of sources, R = NUM_IN/32.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, the channel selector, all enable bits, all forced-pending bits and the master disable are zero. Every `irq_o` line is low and `rdata` is zero.
- R2: The enable word for bank i is at byte offset 0x4 + 4i, for i in 0..R-1. Its bit b belongs to source (R-1-i)*32 + b. Writing the word stores it, and reading the word returns it.
- R3: The forced-pending word for bank i is at 4R + 0x4 + 4i and uses the same bit mapping as R2. A forced bit counts as pending until software writes it back to 0, even while the raw source is low.
- R4: The status word for bank i is at 8R + 0x4 + 4i and uses the same bit mapping as R2. Each bit reads as (source OR forced bit) AND enable bit. Writes to a status word change nothing.
- R5: Group j covers sources 64j to 64j+63. It counts as active while any of its status bits is 1. The output stays high for as long as that level lasts.
- R6: A source whose enable bit is 0 can never make its group active, whether it is driven by the raw input or by its forced bit.
- R7: The master disable word is at 12R + 0x4. When its bit j is 1, every output line of group j is low.
- R8: The master status word is at 12R + 0x8. Bit j is the OR of the status bits of group j, and the master disable does not affect it.
- R9: The channel selector is at offset 0x0 and is NUM_CH bits wide. Output line `irq_o[c*NUM_OUT + j]` is high when group j is active, channel bit c is set and group j is not disabled. With the selector at zero, all outputs are low.
- R10: A read of an offset that is misaligned or lies outside the map returns zero. A write to such an offset changes no state.
- R11: `irq_o` changes at the first clock edge after the input or register change that causes it. `rdata` is loaded at the clock edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IN | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CH*NUM_OUT | Output lines, channel-major, one per group per channel |

## Verification
A wrong enable or forced bit shows up two ways. On the output lines it appears one edge after the source changes. On a status or bank readback it appears one cycle after the read strobe. A bad reversed index moves a source into the wrong bank word, and possibly into the wrong group. Comparing every cycle against a behavioural model finds such a fault on the first cycle in which that source matters. Directed steps fix the bit positions, so that a mapping error cannot be hidden by a model that shares it.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int WORD_W  = 32;
  localparam int GROUP_W = 64;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CHAN,
    RG_MASK,
    RG_SET,
    RG_STAT,
    RG_MDIS,
    RG_MSTAT
  } region_e;
endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_MASK_LO = WA_W'(1);
  localparam logic [WA_W-1:0] W_SET_LO  = WA_W'(NUM_REG + 1);
  localparam logic [WA_W-1:0] W_STAT_LO = WA_W'(2 * NUM_REG + 1);
  localparam logic [WA_W-1:0] W_MDIS    = WA_W'(3 * NUM_REG + 1);
  localparam logic [WA_W-1:0] W_MSTAT   = WA_W'(3 * NUM_REG + 2);

  logic [WA_W-1:0] wa;
  assign wa = addr[ADDR_W-1:2];

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (addr[1:0] == 2'b00) begin
      if (wa == '0) begin
        region = RG_CHAN;
      end else if (wa < W_SET_LO) begin
        region = RG_MASK;
        idx    = IDX_W'(wa - W_MASK_LO);
      end else if (wa < W_STAT_LO) begin
        region = RG_SET;
        idx    = IDX_W'(wa - W_SET_LO);
      end else if (wa < W_MDIS) begin
        region = RG_STAT;
        idx    = IDX_W'(wa - W_STAT_LO);
      end else if (wa == W_MDIS) begin
        region = RG_MDIS;
      end else if (wa == W_MSTAT) begin
        region = RG_MSTAT;
      end
    end
  end
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_IN  = 128,
  parameter int NUM_CH  = 2,
  parameter int NUM_OUT = 2,
  parameter int NUM_REG = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wdata,
  input  region_e            region,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_CH-1:0]  chan_q,
  output logic [NUM_IN-1:0]  mask_q,
  output logic [NUM_IN-1:0]  set_q,
  output logic [NUM_OUT-1:0] mdis_q
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REG - 1);

  logic [NUM_CH-1:0]  chan_d;
  logic [NUM_IN-1:0]  mask_d;
  logic [NUM_IN-1:0]  set_d;
  logic [NUM_OUT-1:0] mdis_d;
  logic [IDX_W-1:0]   slot;

  // bank word 0 holds the top sources
  assign slot = TOP_IDX - idx;

  always_comb begin
    chan_d = chan_q;
    mask_d = mask_q;
    set_d  = set_q;
    mdis_d = mdis_q;
    if (wr_en) begin
      case (region)
        RG_CHAN: chan_d = wdata[NUM_CH-1:0];
        RG_MASK: mask_d[WORD_W*int'(slot) +: WORD_W] = wdata;
        RG_SET:  set_d[WORD_W*int'(slot) +: WORD_W]  = wdata;
        RG_MDIS: mdis_d = wdata[NUM_OUT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      mask_q <= '0;
      set_q  <= '0;
      mdis_q <= '0;
    end else begin
      chan_q <= chan_d;
      mask_q <= mask_d;
      set_q  <= set_d;
      mdis_q <= mdis_d;
    end
  end

  // R4: writes aimed at status words leave configuration untouched
  p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_STAT) |=> ($stable(mask_q) && $stable(set_q)
                                     && $stable(chan_q) && $stable(mdis_q)));

  // R10: writes outside the map leave configuration untouched
  p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_NONE) |=> ($stable(mask_q) && $stable(set_q)
                                     && $stable(chan_q) && $stable(mdis_q)));
endmodule

// File: rtl/irq_steer_reduce.sv
module irq_steer_reduce
  import irq_steer_pkg::*;
#(
  parameter int NUM_IN  = 128,
  parameter int NUM_OUT = 2
) (
  input  logic [NUM_IN-1:0]  irq_i,
  input  logic [NUM_IN-1:0]  mask_q,
  input  logic [NUM_IN-1:0]  set_q,
  output logic [NUM_IN-1:0]  status,
  output logic [NUM_OUT-1:0] grp_or
);
  assign status = (irq_i | set_q) & mask_q;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_grp
    localparam int LO = j * GROUP_W;
    localparam int HI = ((j + 1) * GROUP_W > NUM_IN) ? NUM_IN - 1 : (j + 1) * GROUP_W - 1;
    assign grp_or[j] = |status[HI:LO];
  end
endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
  import irq_steer_pkg::*;
#(
  parameter int NUM_IN = 128,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  localparam int NUM_OUT = (NUM_IN + GROUP_W - 1) / GROUP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IN-1:0]         irq_i,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORD_W-1:0]         rdata,
  output logic [NUM_CH*NUM_OUT-1:0] irq_o
);
  localparam int NUM_REG = NUM_IN / WORD_W;
  localparam int IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REG - 1);

  region_e             region;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    slot;
  logic [NUM_CH-1:0]   chan_q;
  logic [NUM_IN-1:0]   mask_q;
  logic [NUM_IN-1:0]   set_q;
  logic [NUM_OUT-1:0]  mdis_q;
  logic [NUM_IN-1:0]   status;
  logic [NUM_OUT-1:0]  grp_or;
  logic [WORD_W-1:0]   rd_word;
  logic [WORD_W-1:0]   rdata_d, rdata_q;
  logic [NUM_CH*NUM_OUT-1:0] irq_d, irq_q;

  irq_steer_decode #(.NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr   (addr),
    .region (region),
    .idx    (idx)
  );

  irq_steer_regs #(
    .NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT),
    .NUM_REG(NUM_REG), .IDX_W(IDX_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .region (region),
    .idx    (idx),
    .chan_q (chan_q),
    .mask_q (mask_q),
    .set_q  (set_q),
    .mdis_q (mdis_q)
  );

  irq_steer_reduce #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_reduce (
    .irq_i  (irq_i),
    .mask_q (mask_q),
    .set_q  (set_q),
    .status (status),
    .grp_or (grp_or)
  );

  assign slot = TOP_IDX - idx;

  // readback select
  always_comb begin
    rd_word = '0;
    case (region)
      RG_CHAN:  rd_word[NUM_CH-1:0]  = chan_q;
      RG_MASK:  rd_word = mask_q[WORD_W*int'(slot) +: WORD_W];
      RG_SET:   rd_word = set_q[WORD_W*int'(slot) +: WORD_W];
      RG_STAT:  rd_word = status[WORD_W*int'(slot) +: WORD_W];
      RG_MDIS:  rd_word[NUM_OUT-1:0] = mdis_q;
      RG_MSTAT: rd_word[NUM_OUT-1:0] = grp_or;
      default:  rd_word = '0;
    endcase
  end

  assign rdata_d = rd_en ? rd_word : rdata_q;

  // steering: channel-major output vector
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign irq_d[c*NUM_OUT +: NUM_OUT] = grp_or & ~mdis_q & {NUM_OUT{chan_q[c]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
    end
  end

  assign rdata = rdata_q;
  assign irq_o = irq_q;

  // R11: read data holds between read strobes
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));

  // R9: no channel selected means silence on the next edge
  p_chan_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_q == '0) |=> (irq_q == '0));

  // R5: with no raw or forced source, every line drops
  p_no_src_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i == '0 && set_q == '0) |=> (irq_q == '0));

  // R7: a disabled group stays low on every channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mdis_chk_c
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_mdis_chk_j
      p_mdis_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdis_q[j] |=> !irq_q[c*NUM_OUT+j]);
    end
  end
endmodule

// File: tb/irq_steer_agg_tb.sv
`timescale 1ns/1ps
module irq_steer_agg_tb_top;
  localparam int NI  = 128;
  localparam int NCH = 2;
  localparam int AW  = 8;
  localparam int R   = NI / 32;
  localparam int NO  = (NI + 63) / 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NI-1:0]     irq_i = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH*NO-1:0] irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  irq_steer_agg #(.NUM_IN(NI), .NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // behavioural reference state
  bit          m_mask [NI];
  bit          m_set  [NI];
  bit [NCH-1:0] m_chan;
  bit [NO-1:0]  m_mdis;
  logic [NCH*NO-1:0] exp_irq;
  logic [31:0]       exp_rd;

  function automatic bit m_pend(int k);
    return (irq_i[k] | m_set[k]) & m_mask[k];
  endfunction

  function automatic bit m_group(int j);
    bit g = 0;
    for (int k = 64*j; k < 64*j+64 && k < NI; k++) if (m_pend(k)) g = 1;
    return g;
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] v = '0;
    int w = a / 4;
    if (a % 4 != 0) return '0;
    if (w == 0) v[NCH-1:0] = m_chan;
    else if (w <= R) begin
      for (int b = 0; b < 32; b++) v[b] = m_mask[(R-w)*32+b];
    end else if (w <= 2*R) begin
      for (int b = 0; b < 32; b++) v[b] = m_set[(2*R-w)*32+b];
    end else if (w <= 3*R) begin
      for (int b = 0; b < 32; b++) v[b] = m_pend((3*R-w)*32+b);
    end else if (w == 3*R+1) v[NO-1:0] = m_mdis;
    else if (w == 3*R+2) begin
      for (int j = 0; j < NO; j++) v[j] = m_group(j);
    end
    return v;
  endfunction

  task automatic m_write(int a, logic [31:0] d);
    int w = a / 4;
    if (a % 4 != 0) return;
    if (w == 0) m_chan = d[NCH-1:0];
    else if (w <= R) begin
      for (int b = 0; b < 32; b++) m_mask[(R-w)*32+b] = d[b];
    end else if (w <= 2*R) begin
      for (int b = 0; b < 32; b++) m_set[(2*R-w)*32+b] = d[b];
    end else if (w == 3*R+1) m_mdis = d[NO-1:0];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NI; k++) begin m_mask[k] = 0; m_set[k] = 0; end
      m_chan = '0; m_mdis = '0; exp_irq = '0; exp_rd = '0;
    end else begin
      logic [NCH*NO-1:0] nx;
      for (int c = 0; c < NCH; c++)
        for (int j = 0; j < NO; j++)
          nx[c*NO+j] = m_group(j) & m_chan[c] & ~m_mdis[j];
      if (rd_en) exp_rd = m_read(int'(addr));
      if (wr_en) m_write(int'(addr), wdata);
      exp_irq = nx;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, expv, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (chk_on) begin
      chk("irq_o model", 32'(irq_o), 32'(exp_irq));
      chk("rdata model", rdata, exp_rd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd_expect(int a, logic [31:0] expv, string what);
    rd(a);
    chk(what, rdata, expv);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state before release
    chk("irq_o in reset", 32'(irq_o), 32'h0);
    chk("rdata in reset", rdata, 32'h0);
    rst_n = 1;
    chk_on = 1;
    cur_req = "R1";
    for (int a = 0; a <= 16*4; a += 4) rd_expect(a, 32'h0, "R1 reset readback");

    // R2: bank 0 holds sources 96..127
    cur_req = "R2";
    wr(32'h00, 32'h1);
    wr(32'h04, 32'hFFFF_FFFF);
    rd_expect(32'h04, 32'hFFFF_FFFF, "R2 mask readback");
    @(negedge clk); irq_i[100] = 1;
    idle(2);
    chk("R2 source 100 -> group 1 ch0", 32'(irq_o), 32'h2);
    cur_req = "R4";
    rd_expect(32'h24, 32'h0000_0010, "R4 status bank0 bit4");
    // R5: level held keeps the line up, dropping it releases
    cur_req = "R5";
    idle(5);
    chk("R5 level held", 32'(irq_o), 32'h2);
    @(negedge clk); irq_i[100] = 0;
    idle(2);
    chk("R5 level released", 32'(irq_o), 32'h0);

    // R11: one-edge latency, source 0 in bank 3
    cur_req = "R11";
    wr(32'h10, 32'h0000_0001);
    idle(1);
    @(negedge clk); irq_i[0] = 1;
    #1 chk("R11 before edge", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk("R11 after edge", 32'(irq_o), 32'h1);

    // R6: clearing the enable bit blocks the source
    cur_req = "R6";
    wr(32'h10, 32'h0);
    idle(2);
    chk("R6 masked source", 32'(irq_o), 32'h0);
    @(negedge clk); irq_i[0] = 0;

    // R3: forced bit 5 of bank 3 (source 5) with enable
    cur_req = "R3";
    wr(32'h10, 32'hFFFF_FFFF);
    wr(32'h20, 32'h0000_0020);
    idle(2);
    chk("R3 forced pending", 32'(irq_o), 32'h1);
    rd_expect(32'h30, 32'h0000_0020, "R3 status shows forced bit");

    // R4: a write to status is ignored
    cur_req = "R4";
    wr(32'h30, 32'h0);
    rd_expect(32'h30, 32'h0000_0020, "R4 status write ignored");
    rd_expect(32'h20, 32'h0000_0020, "R4 set word untouched");

    // R7 / R8: disable group 0, master status still shows it
    cur_req = "R7";
    wr(32'h34, 32'h1);
    idle(2);
    chk("R7 group0 disabled", 32'(irq_o), 32'h0);
    cur_req = "R8";
    rd_expect(32'h38, 32'h1, "R8 master status ignores disable");
    wr(32'h34, 32'h0);

    // R9: channel steering
    cur_req = "R9";
    wr(32'h00, 32'h2);
    idle(2);
    chk("R9 channel 1", 32'(irq_o), 32'h4);
    wr(32'h00, 32'h0);
    idle(2);
    chk("R9 no channel", 32'(irq_o), 32'h0);
    wr(32'h00, 32'h3);
    idle(2);
    chk("R9 both channels", 32'(irq_o), 32'h5);

    // R10: unmapped and misaligned offsets
    cur_req = "R10";
    wr(32'h3C, 32'hFFFF_FFFF);
    wr(32'h01, 32'h0);
    wr(32'h22, 32'h0);
    rd_expect(32'h3C, 32'h0, "R10 unmapped read");
    rd_expect(32'h06, 32'h0, "R10 misaligned read");
    rd_expect(32'h80, 32'h0, "R10 far read");
    rd_expect(32'h00, 32'h3, "R10 channel unchanged");
    rd_expect(32'h20, 32'h0000_0020, "R10 set word unchanged");
    // R3: software clear of the forced bit
    cur_req = "R3";
    wr(32'h20, 32'h0);
    idle(2);
    chk("R3 forced bit cleared", 32'(irq_o), 32'h0);

    // mixed traffic against the model
    cur_req = "R5 R11 mixed";
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      if ($urandom % 8 == 0)
        irq_i = {$urandom, $urandom, $urandom, $urandom} &
                {$urandom, $urandom, $urandom, $urandom} &
                {$urandom, $urandom, $urandom, $urandom};
      op = int'($urandom % 4);
      addr = AW'(($urandom % 18) * 4 + (($urandom % 16 == 0) ? 1 : 0));
      wdata = $urandom & $urandom;
      if (op == 0) wr_en = 1;
      else if (op == 1) rd_en = 1;
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    idle(3);
    finish_run();
  end
endmodule